// File: doc/BRIEF.md
# Pulse Width Measurement Timer Channel

This block is one timer channel that measures how long an external input stays at a chosen level. Software fires a start strobe, which arms the channel. The channel then waits for the input to enter the level being measured. On that start edge the counter clears to zero. It then advances once on every cycle in which the prescaler tick is high. When the input leaves the level, that is on the capture edge, the running count is latched into the data output and a one-cycle interrupt pulse is raised.

An overflow status is rewritten at every capture. It shows whether the counter wrapped during the measurement just finished. Between measurements the counter freezes. Each new start edge begins the next measurement. A stop strobe disarms the channel and keeps the counter and overflow status as they are.

The input passes through a synchronizer and, if enabled, through a noise filter. The filter accepts a new level only after it has been stable for a set number of samples. The level mode and the filter enable are loaded through a configuration write. That write is accepted only while the channel is disarmed.

Top module: `pwt_channel`

## Requirements
- R1: After reset, `cnt_val`, `cap_data`, `ovf`, `run_en` and `irq` are all zero.
- R2: A `start_trg` pulse sets `run_en` to 1 on the next cycle. The counter keeps its value until a start edge appears on the conditioned input.
- R3: A start edge clears the counter to 0. After that the counter advances by one only on cycles where `tick_en` is 1. With `tick_en` held at 0 the counter stays at 0.
- R4: A capture edge copies the counter into `cap_data` and raises `irq` for exactly one cycle. With `tick_en` held at 1 and filtering on or off, an input pulse of P cycles gives `cap_data` = P-1 (mod 2^CNT_W).
- R5: At each capture, `ovf` is set to 1 if the counter wrapped from all-ones to zero during the measurement. Otherwise it is cleared to 0.
- R6: After a capture the counter holds the captured value until the next start edge. The following pulse is then measured the same way.
- R7: A `stop_trg` pulse clears `run_en`. It stops counting, keeps `cnt_val` and `ovf`, and no capture follows. If `start_trg` and `stop_trg` arrive in the same cycle, stop wins.
- R8: A configuration write (`cfg_wr`) has no effect while `run_en` is 1. It takes effect when `run_en` is 0.
- R9: Level mode `cfg_level` = 0 measures the high level: start on a rising edge, capture on a falling edge. `cfg_level` = 1 measures the low level: start on a falling edge, capture on a rising edge.
- R10: With `cfg_filt_en` = 1, an input pulse shorter than FILT_LEN (default 2) clocks is ignored and no capture occurs. With `cfg_filt_en` = 0, a one-cycle pulse is measured as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-enable tick from the prescaler |
| pin_in | input | 1 | Input whose level width is measured |
| start_trg | input | 1 | One-cycle arm strobe |
| stop_trg | input | 1 | One-cycle disarm strobe |
| cfg_wr | input | 1 | Loads cfg_level and cfg_filt_en when disarmed |
| cfg_level | input | 1 | 0: measure high level, 1: measure low level |
| cfg_filt_en | input | 1 | Noise filter enable |
| cap_data | output | CNT_W | Captured width |
| ovf | output | 1 | Counter wrapped during last measurement |
| run_en | output | 1 | Channel armed |
| cnt_val | output | CNT_W | Live counter |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
The assertions assume that `start_trg` and `stop_trg` are single-cycle strobes. They also assume that the input alternates cleanly, so a start edge is always followed by a capture edge before the next start edge.

The bench changes the input only on the falling clock edge. It holds the input at the idle level of the selected mode before each arm. It keeps every pulse apart by enough cycles to clear the synchronizer and filter latency. The expected widths depend only on pulse lengths counted in clock cycles, so the fixed input latency cancels out.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_COUNT = 2'd2
   } pwt_state_e;

   typedef enum logic {
      LVL_HIGH = 1'b0,
      LVL_LOW  = 1'b1
   } pwt_level_e;
endpackage

// File: rtl/pwt_in_cond.sv
module pwt_in_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic filt_en,
   output logic lvl_out
);
   localparam int SMSB = SYNC_STAGES - 1;

   logic [SMSB:0] sync_q;
   logic          sync_lvl;
   logic          filt_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SMSB-1:0], pin_in};
   end
   assign sync_lvl = sync_q[SMSB];

   generate
      if (FILT_LEN > 1) begin : g_filt
         logic [FILT_LEN-1:0] hist_q;
         logic                acc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '0;
               acc_q  <= 1'b0;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], sync_lvl};
               if (&hist_q)       acc_q <= 1'b1;
               else if (~|hist_q) acc_q <= 1'b0;
            end
         end
         assign filt_lvl = acc_q;
      end else begin : g_nofilt
         assign filt_lvl = sync_lvl;
      end
   endgenerate

   assign lvl_out = filt_en ? filt_lvl : sync_lvl;
endmodule

// File: rtl/pwt_edge.sv
module pwt_edge
   import pwt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  pwt_level_e mode,
   output logic       start_edge,
   output logic       cap_edge
);
   logic prev_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   always_comb begin
      if (mode == LVL_LOW) begin
         start_edge = fall;
         cap_edge   = rise;
      end else begin
         start_edge = rise;
         cap_edge   = fall;
      end
   end
endmodule

// File: rtl/pwt_core.sv
module pwt_core
   import pwt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             start_trg,
   input  logic             stop_trg,
   input  logic             start_edge,
   input  logic             cap_edge,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cap_q,
   output logic             ovf_q,
   output logic             run_q,
   output logic             irq_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   pwt_state_e state_q;
   logic       wrap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         cap_q   <= '0;
         ovf_q   <= 1'b0;
         run_q   <= 1'b0;
         irq_q   <= 1'b0;
         wrap_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (stop_trg) begin
            run_q   <= 1'b0;
            state_q <= ST_IDLE;
         end else if (start_trg) begin
            run_q   <= 1'b1;
            state_q <= ST_WAIT;
         end else begin
            case (state_q)
               ST_WAIT: begin
                  if (start_edge) begin
                     cnt_q   <= '0;
                     wrap_q  <= 1'b0;
                     state_q <= ST_COUNT;
                  end
               end
               ST_COUNT: begin
                  if (cap_edge) begin
                     cap_q   <= cnt_q;
                     ovf_q   <= wrap_q;
                     irq_q   <= 1'b1;
                     state_q <= ST_WAIT;
                  end else if (tick_en) begin
                     cnt_q <= cnt_q + 1'b1;
                     if (cnt_q == CNT_MAX) wrap_q <= 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/pwt_channel.sv
module pwt_channel
   import pwt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             pin_in,
   input  logic             start_trg,
   input  logic             stop_trg,
   input  logic             cfg_wr,
   input  logic             cfg_level,
   input  logic             cfg_filt_en,
   output logic [CNT_W-1:0] cap_data,
   output logic             ovf,
   output logic             run_en,
   output logic [CNT_W-1:0] cnt_val,
   output logic             irq
);
   generate
      if (CNT_W < 2)       begin : g_bad_w    $error("CNT_W must be at least 2");       end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
      if (FILT_LEN < 1)    begin : g_bad_filt $error("FILT_LEN must be at least 1");    end
   endgenerate

   pwt_level_e mode_q;
   logic       filt_q;
   logic       lvl;
   logic       start_edge;
   logic       cap_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= LVL_HIGH;
         filt_q <= 1'b0;
      end else if (cfg_wr && !run_en) begin
         mode_q <= pwt_level_e'(cfg_level);
         filt_q <= cfg_filt_en;
      end
   end

   pwt_in_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .filt_en(filt_q), .lvl_out(lvl)
   );

   pwt_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .mode(mode_q),
      .start_edge(start_edge), .cap_edge(cap_edge)
   );

   pwt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .start_trg(start_trg), .stop_trg(stop_trg),
      .start_edge(start_edge), .cap_edge(cap_edge),
      .cnt_q(cnt_val), .cap_q(cap_data), .ovf_q(ovf),
      .run_q(run_en), .irq_q(irq)
   );
endmodule

// File: rtl/pwt_channel_chk.sv
module pwt_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_trg,
   input logic             stop_trg,
   input logic [CNT_W-1:0] cap_data,
   input logic             ovf,
   input logic             run_en,
   input logic [CNT_W-1:0] cnt_val,
   input logic             irq
);
   p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_trg && !stop_trg) |=> run_en);

   p_stop_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_trg |=> !run_en);

   p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_cap_only_on_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_data) |-> irq);

   p_cnt_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(cnt_val));

   p_ovf_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(ovf));

   p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt_val) && cnt_val != '0) |-> (cnt_val == $past(cnt_val) + 1'b1));
endmodule

bind pwt_channel pwt_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_trg(start_trg), .stop_trg(stop_trg),
   .cap_data(cap_data), .ovf(ovf), .run_en(run_en), .cnt_val(cnt_val), .irq(irq)
);

// File: tb/pwt_channel_tb.sv
`timescale 1ns/1ps
module pwt_channel_tb;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b1;
   logic          pin_in = 1'b0;
   logic          start_trg = 1'b0;
   logic          stop_trg = 1'b0;
   logic          cfg_wr = 1'b0;
   logic          cfg_level = 1'b0;
   logic          cfg_filt_en = 1'b0;
   logic [CW-1:0] cap_data;
   logic          ovf;
   logic          run_en;
   logic [CW-1:0] cnt_val;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;
   int n_irq  = 0;
   int n_irq_wide = 0;
   logic irq_prev = 1'b0;

   always #2.5 clk = ~clk;

   pwt_channel #(.CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pin_in(pin_in),
      .start_trg(start_trg), .stop_trg(stop_trg), .cfg_wr(cfg_wr),
      .cfg_level(cfg_level), .cfg_filt_en(cfg_filt_en),
      .cap_data(cap_data), .ovf(ovf), .run_en(run_en),
      .cnt_val(cnt_val), .irq(irq)
   );

   always @(negedge clk) begin
      if (irq) n_irq++;
      if (irq && irq_prev) n_irq_wide++;
      irq_prev = irq;
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe_start();
      start_trg = 1'b1; cyc(1); start_trg = 1'b0; cyc(1);
   endtask

   task automatic strobe_stop();
      stop_trg = 1'b1; cyc(1); stop_trg = 1'b0; cyc(1);
   endtask

   task automatic set_cfg(logic lvl, logic filt);
      cfg_level = lvl; cfg_filt_en = filt; cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
   endtask

   task automatic pulse(logic active, int p);
      pin_in = active; cyc(p); pin_in = ~active; cyc(12);
   endtask

   task automatic t_reset();
      chk("R1 cnt_val", int'(cnt_val), 0);
      chk("R1 cap_data", int'(cap_data), 0);
      chk("R1 ovf", int'(ovf), 0);
      chk("R1 run_en", int'(run_en), 0);
      chk("R1 irq", int'(irq), 0);
   endtask

   task automatic t_arm_wait();
      strobe_start();
      chk("R2 run_en after start", int'(run_en), 1);
      cyc(10);
      chk("R2 no count before start edge", int'(cnt_val), 0);
   endtask

   task automatic t_high_basic();
      int base;
      base = n_irq;
      pulse(1'b1, 20);
      chk("R4 cap width 20", int'(cap_data), 19);
      chk("R4 one irq", n_irq - base, 1);
      chk("R5 no wrap", int'(ovf), 0);
      chk("R6 counter holds capture", int'(cnt_val), 19);
      cyc(8);
      chk("R6 counter still held", int'(cnt_val), 19);
      pulse(1'b1, 7);
      chk("R6 repeat measurement", int'(cap_data), 6);
   endtask

   task automatic t_no_tick();
      tick_en = 1'b0;
      pulse(1'b1, 15);
      chk("R3 no tick gives zero", int'(cap_data), 0);
      tick_en = 1'b1;
   endtask

   task automatic t_overflow();
      pulse(1'b1, 300);
      chk("R5 wrapped width", int'(cap_data), (300 - 1) % 256);
      chk("R5 ovf set", int'(ovf), 1);
      pulse(1'b1, 10);
      chk("R5 ovf cleared", int'(ovf), 0);
      chk("R5 width after wrap", int'(cap_data), 9);
   endtask

   task automatic t_cfg_locked();
      int base;
      set_cfg(1'b1, 1'b1);
      base = n_irq;
      pulse(1'b1, 5);
      chk("R8 cfg ignored, still high mode", int'(cap_data), 4);
      chk("R8 irq count", n_irq - base, 1);
      pulse(1'b1, 1);
      chk("R10 unfiltered 1-cycle pulse", int'(cap_data), 0);
   endtask

   task automatic t_stop();
      logic [CW-1:0] held;
      int base;
      base = n_irq;
      pin_in = 1'b1; cyc(20);
      strobe_stop();
      chk("R7 run_en cleared", int'(run_en), 0);
      held = cnt_val;
      cyc(10);
      chk("R7 counter held", int'(cnt_val), int'(held));
      chk("R7 ovf held", int'(ovf), 0);
      pin_in = 1'b0; cyc(12);
      chk("R7 no capture after stop", n_irq - base, 0);
      chk("R7 counter held past edge", int'(cnt_val), int'(held));
   endtask

   task automatic t_low_filter();
      int base;
      set_cfg(1'b1, 1'b1);
      pin_in = 1'b1; cyc(10);
      strobe_start();
      pulse(1'b0, 9);
      chk("R9 low level width", int'(cap_data), 8);
      base = n_irq;
      pulse(1'b0, 1);
      chk("R10 filtered glitch ignored", n_irq - base, 0);
      pulse(1'b0, 4);
      chk("R10 filtered width", int'(cap_data), 3);
   endtask

   task automatic t_start_stop_same();
      start_trg = 1'b1; stop_trg = 1'b1; cyc(1);
      start_trg = 1'b0; stop_trg = 1'b0; cyc(1);
      chk("R7 stop beats start", int'(run_en), 0);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_arm_wait();
      t_high_basic();
      t_no_tick();
      t_overflow();
      t_cfg_locked();
      t_stop();
      t_low_filter();
      strobe_stop();
      t_start_stop_same();
      chk("R4 irq never wider than one cycle", n_irq_wide, 0);
      report();
   end

   initial begin
      #(100000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end
endmodule